// File: doc/BRIEF.md
# Two-Wide Next Fetch Address Selector

The selector sits in a fetch stage that reads two consecutive 4-byte instructions per cycle. Each cycle it takes the current group address and per-slot branch target buffer results. A slot's buffer result is a hit flag, a branch kind, a direction guess and a target. From these it produces the address of the next group and a two-bit mask. The mask marks which of the two fetched instructions stay live. Four sources compete for the next address: the sequential group address, a buffer target, a per-slot indirect predictor target, and a resolved address from the back end.

A small return address stack lives inside the block. Call-type branches push the address that follows them. Return-type branches pop the stack and use the popped value as their guess. Only the slot that decides the next address touches the stack. When the stack is full, a push replaces the oldest entry. When the stack is empty, a pop falls back to the buffer target.

Top module: `fetch_next_sel`

## Requirements
- R1: With fetch_valid high, no redirect and no predicted-taken slot, next_pc equals pc + 8 and slot_valid is 2'b11.
- R2: A slot is predicted taken only when its hit bit is set. Kind code 0 (conditional) is taken when its dir bit is 1. Codes 1 (jump), 2 (call), 3 (return) and 4 (indirect) are always taken. Codes 5 to 7 count as not a branch.
- R3: When slot 0 is predicted taken, it alone sets next_pc and slot_valid is 2'b01 (bit 0 is slot 0, bit 1 is slot 1), whatever slot 1 holds.
- R4: When slot 0 is not taken and slot 1 is taken, next_pc comes from slot 1 and slot_valid is 2'b11.
- R5: A deciding indirect slot takes its own ind_tgt input. Conditional, jump and call slots take their own btb_tgt input.
- R6: A deciding call pushes its fall-through address: pc + 4 for slot 0, pc + 8 for slot 1. A deciding return uses the most recently pushed live entry as next_pc and removes it.
- R7: The stack keeps 8 entries. After 9 pushes, 8 returns see the 8 newest addresses, newest first.
- R8: A return on an empty stack uses its btb_tgt, and the stack stays empty.
- R9: redir_valid high forces next_pc to redir_pc and slot_valid to 2'b00, and the stack does not change.
- R10: With fetch_valid low and no redirect, next_pc equals pc, slot_valid is 2'b00, and the stack does not change.
- R11: After reset the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch group is present this cycle |
| pc | input | ADDR_W | Address of slot 0 |
| slot_hit | input | 2 | Buffer hit per slot |
| slot_dir | input | 2 | Direction guess per slot, used for conditional kind |
| kind0 | input | 3 | Branch kind of slot 0 |
| kind1 | input | 3 | Branch kind of slot 1 |
| btb_tgt0 | input | ADDR_W | Buffer target of slot 0 |
| btb_tgt1 | input | ADDR_W | Buffer target of slot 1 |
| ind_tgt0 | input | ADDR_W | Indirect predictor target of slot 0 |
| ind_tgt1 | input | ADDR_W | Indirect predictor target of slot 1 |
| redir_valid | input | 1 | Back-end redirect |
| redir_pc | input | ADDR_W | Resolved address of the redirect |
| next_pc | output | ADDR_W | Next group address |
| slot_valid | output | 2 | Live mask of the fetched slots |

## Verification
The bench uses the default parameters: a 32-bit address and an 8-entry stack. With a depth this small, a run of nine calls reaches the overwrite of the oldest entry. A following run of nine returns drains the stack and reaches the empty-stack fallback. Random groups draw kinds from all five codes in both slots, with rare redirects and idle cycles. This mix exercises first-slot priority and the case where a call in slot 1 is masked because slot 0 is taken.

// File: rtl/fns_pkg.sv
package fns_pkg;
    parameter int unsigned ADDR_W     = 32;
    parameter int unsigned INSN_BYTES = 4;
    localparam int unsigned GROUP_W   = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        BK_COND = 3'd0,
        BK_JUMP = 3'd1,
        BK_CALL = 3'd2,
        BK_RET  = 3'd3,
        BK_IND  = 3'd4
    } br_kind_e;

    typedef struct packed {
        logic taken;
        logic is_call;
        logic is_ret;
        logic is_ind;
    } slot_dec_t;

    function automatic addr_t slot_after(addr_t base, int unsigned slot);
        return base + addr_t'((slot + 1) * INSN_BYTES);
    endfunction
endpackage

// File: rtl/fns_slot_decode.sv
module fns_slot_decode
    import fns_pkg::*;
(
    input  logic       hit,
    input  logic       dir,
    input  logic [2:0] kind,
    output slot_dec_t  dec
);
    br_kind_e k;
    always_comb begin
        k           = br_kind_e'(kind);
        dec         = '0;
        dec.is_call = hit && (k == BK_CALL);
        dec.is_ret  = hit && (k == BK_RET);
        dec.is_ind  = hit && (k == BK_IND);
        case (k)
            BK_COND:                        dec.taken = hit && dir;
            BK_JUMP, BK_CALL, BK_RET, BK_IND: dec.taken = hit;
            default:                        dec.taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/fns_ras.sv
module fns_ras
    import fns_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  addr_t push_addr,
    output logic  top_valid,
    output addr_t top_addr
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    addr_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        rd_ptr    = (wr_ptr == '0) ? PTR_LAST : (wr_ptr - PTR_ONE);
        top_valid = (cnt != '0);
        top_addr  = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (push) begin
            wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : (wr_ptr + PTR_ONE);
            if (cnt != CNT_FULL) cnt <= cnt + CNT_ONE;
        end else if (pop && cnt != '0) begin
            wr_ptr <= rd_ptr;
            cnt    <= cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_addr;
    end
endmodule

// File: rtl/fetch_next_sel.sv
module fetch_next_sel
    import fns_pkg::*;
#(
    parameter int unsigned RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic [1:0]        slot_hit,
    input  logic [1:0]        slot_dir,
    input  logic [2:0]        kind0,
    input  logic [2:0]        kind1,
    input  logic [ADDR_W-1:0] btb_tgt0,
    input  logic [ADDR_W-1:0] btb_tgt1,
    input  logic [ADDR_W-1:0] ind_tgt0,
    input  logic [ADDR_W-1:0] ind_tgt1,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic [1:0]        slot_valid
);
    logic [2:0] kinds   [GROUP_W];
    addr_t      btb     [GROUP_W];
    addr_t      ind     [GROUP_W];
    slot_dec_t  dec     [GROUP_W];
    addr_t      tgt     [GROUP_W];
    addr_t      fall    [GROUP_W];

    logic  ras_valid;
    addr_t ras_top;
    logic  do_push, do_pop;
    addr_t push_addr;

    assign kinds[0] = kind0;
    assign kinds[1] = kind1;
    assign btb[0]   = btb_tgt0;
    assign btb[1]   = btb_tgt1;
    assign ind[0]   = ind_tgt0;
    assign ind[1]   = ind_tgt1;

    for (genvar s = 0; s < GROUP_W; s++) begin : g_slot
        fns_slot_decode u_dec (
            .hit  (slot_hit[s]),
            .dir  (slot_dir[s]),
            .kind (kinds[s]),
            .dec  (dec[s])
        );
        always_comb begin
            fall[s] = slot_after(pc, s);
            if (dec[s].is_ind)
                tgt[s] = ind[s];
            else if (dec[s].is_ret && ras_valid)
                tgt[s] = ras_top;
            else
                tgt[s] = btb[s];
        end
    end

    always_comb begin
        next_pc    = pc;
        slot_valid = 2'b00;
        do_push    = 1'b0;
        do_pop     = 1'b0;
        push_addr  = fall[0];
        if (redir_valid) begin
            next_pc = redir_pc;
        end else if (fetch_valid) begin
            if (dec[0].taken) begin
                next_pc    = tgt[0];
                slot_valid = 2'b01;
                do_push    = dec[0].is_call;
                do_pop     = dec[0].is_ret;
                push_addr  = fall[0];
            end else if (dec[1].taken) begin
                next_pc    = tgt[1];
                slot_valid = 2'b11;
                do_push    = dec[1].is_call;
                do_pop     = dec[1].is_ret;
                push_addr  = fall[1];
            end else begin
                next_pc    = fall[1];
                slot_valid = 2'b11;
            end
        end
    end

    fns_ras #(.DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (push_addr),
        .top_valid (ras_valid),
        .top_addr  (ras_top)
    );
endmodule

// File: rtl/fns_checker.sv
module fns_checker
    import fns_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] pc,
    input logic [1:0]        slot_hit,
    input logic [1:0]        slot_dir,
    input logic [2:0]        kind0,
    input logic [2:0]        kind1,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic [1:0]        slot_valid
);
    logic t0, t1, live, call0, ret0;
    always_comb begin
        t0 = slot_hit[0] && ((kind0 == 3'd0) ? slot_dir[0] : (kind0 >= 3'd1 && kind0 <= 3'd4));
        t1 = slot_hit[1] && ((kind1 == 3'd0) ? slot_dir[1] : (kind1 >= 3'd1 && kind1 <= 3'd4));
        live  = fetch_valid && !redir_valid;
        call0 = live && slot_hit[0] && kind0 == 3'd2;
        ret0  = live && slot_hit[0] && kind0 == 3'd3;
    end

    a_r1_sequential: assert property (@(posedge clk) disable iff (rst)
        (live && !t0 && !t1) |-> (next_pc == pc + ADDR_W'(8) && slot_valid == 2'b11));

    a_r3_first_slot_kills_second: assert property (@(posedge clk) disable iff (rst)
        (live && t0) |-> (slot_valid == 2'b01));

    a_r4_second_slot_keeps_both: assert property (@(posedge clk) disable iff (rst)
        (live && !t0 && t1) |-> (slot_valid == 2'b11));

    a_r6_call_then_return: assert property (@(posedge clk) disable iff (rst)
        call0 ##1 ret0 |-> (next_pc == $past(pc) + ADDR_W'(4)));

    a_r9_redirect_wins: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (next_pc == redir_pc && slot_valid == 2'b00));

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!fetch_valid && !redir_valid) |-> (next_pc == pc && slot_valid == 2'b00));
endmodule

bind fetch_next_sel fns_checker u_chk (.*);

// File: tb/fetch_next_sel_tb.sv
module fetch_next_sel_tb;
    import fns_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fv = 1'b0;
    addr_t      pc = '0;
    logic [1:0] hit = '0;
    logic [1:0] dir = '0;
    logic [2:0] kind [2] = '{3'd0, 3'd0};
    addr_t      btb  [2] = '{'0, '0};
    addr_t      ind  [2] = '{'0, '0};
    logic       redir = 1'b0;
    addr_t      rpc = '0;
    addr_t      next_pc;
    logic [1:0] slot_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    addr_t model [$];

    always #4 clk = ~clk;

    fetch_next_sel u_dut (
        .clk(clk), .rst(rst), .fetch_valid(fv), .pc(pc),
        .slot_hit(hit), .slot_dir(dir), .kind0(kind[0]), .kind1(kind[1]),
        .btb_tgt0(btb[0]), .btb_tgt1(btb[1]), .ind_tgt0(ind[0]), .ind_tgt1(ind[1]),
        .redir_valid(redir), .redir_pc(rpc), .next_pc(next_pc), .slot_valid(slot_valid)
    );

    function automatic bit is_taken(int s);
        if (!hit[s]) return 0;
        if (kind[s] == 3'd0) return dir[s];
        return (kind[s] >= 3'd1 && kind[s] <= 3'd4);
    endfunction

    task automatic report(string tag, addr_t got_pc, logic [1:0] got_m, addr_t exp_pc, logic [1:0] exp_m);
        checks++;
        if (got_pc !== exp_pc || got_m !== exp_m) begin
            errors++;
            $display("FAIL %s next_pc=%h mask=%b expected next_pc=%h mask=%b", tag, got_pc, got_m, exp_pc, exp_m);
        end
    endtask

    // Inputs are already driven after a negedge; check, then advance the model.
    task automatic check_cycle(string extra);
        addr_t      e_pc;
        logic [1:0] e_m;
        string      tag;
        int         op = 0;
        int         dec = -1;
        addr_t      paddr = '0;
        #1;
        if (redir) begin
            e_pc = rpc; e_m = 2'b00; tag = "R9";
        end else if (!fv) begin
            e_pc = pc; e_m = 2'b00; tag = "R10";
        end else begin
            e_pc = pc + 8; e_m = 2'b11; tag = "R1";
            if (is_taken(0)) dec = 0;
            else if (is_taken(1)) dec = 1;
            if (dec >= 0) begin
                e_m = (dec == 0) ? 2'b01 : 2'b11;
                tag = (dec == 0) ? "R3" : "R4";
                if (kind[dec] == 3'd4) begin
                    e_pc = ind[dec]; tag = {tag, "/R5"};
                end else if (kind[dec] == 3'd3) begin
                    op = 2;
                    if (model.size() > 0) begin
                        e_pc = model[$]; tag = {tag, "/R6"};
                    end else begin
                        e_pc = btb[dec]; tag = {tag, "/R8"};
                    end
                end else begin
                    e_pc = btb[dec];
                    tag = {tag, "/R2"};
                    if (kind[dec] == 3'd2) begin
                        op = 1; paddr = pc + addr_t'(4 * (dec + 1));
                    end
                end
            end
        end
        report({tag, extra}, next_pc, slot_valid, e_pc, e_m);
        if (op == 1) begin
            model.push_back(paddr);
            if (model.size() > 8) void'(model.pop_front());
        end else if (op == 2 && model.size() > 0) begin
            void'(model.pop_back());
        end
    endtask

    task automatic set_group(logic v, addr_t a, logic h0, logic [2:0] k0, logic h1, logic [2:0] k1);
        @(negedge clk);
        fv = v; pc = a; redir = 1'b0;
        hit = {h1, h0}; dir = 2'b00;
        kind[0] = k0; kind[1] = k1;
        btb[0] = a ^ 32'h00F0_0000; btb[1] = a ^ 32'h0F00_0000;
        ind[0] = a ^ 32'h000A_0000; ind[1] = a ^ 32'h00B0_0000;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: fresh stack, return falls back to buffer target
        set_group(1, 32'h0000_2000, 1, 3'd3, 0, 3'd0);
        check_cycle(" R11 empty after reset");

        // R7: nine calls overflow the 8-entry stack, then nine returns
        for (int i = 0; i < 9; i++) begin
            set_group(1, 32'h0000_1000 + 32'(i * 16), 1, 3'd2, 0, 3'd0);
            check_cycle(" R7 push");
        end
        for (int i = 0; i < 9; i++) begin
            set_group(1, 32'h0000_3000 + 32'(i * 16), 1, 3'd3, 0, 3'd0);
            check_cycle(i < 8 ? " R7 pop" : " R8 empty pop");
        end

        // R6: slot 1 call pushes pc+8, after a non-taken conditional in slot 0
        set_group(1, 32'h0000_4000, 1, 3'd0, 1, 3'd2);
        check_cycle(" R6 slot1 call");
        set_group(1, 32'h0000_5000, 0, 3'd0, 1, 3'd3);
        check_cycle(" R6 slot1 return");

        // R3: slot 0 jump masks a slot 1 call, which must not push
        set_group(1, 32'h0000_6000, 1, 3'd1, 1, 3'd2);
        check_cycle(" R3 masked call");
        set_group(1, 32'h0000_6100, 1, 3'd3, 0, 3'd0);
        check_cycle(" R3 no push seen");

        // R9: redirect over a call, then a return must see the empty stack
        set_group(1, 32'h0000_7000, 1, 3'd2, 0, 3'd0);
        redir = 1'b1; rpc = 32'h0000_ABC0;
        check_cycle(" R9 redirect");
        set_group(1, 32'h0000_7100, 1, 3'd3, 0, 3'd0);
        check_cycle(" R9 stack unchanged");

        // R10: idle cycle with a call on the inputs
        set_group(0, 32'h0000_8000, 1, 3'd2, 0, 3'd0);
        check_cycle(" R10 idle");
        set_group(1, 32'h0000_8100, 1, 3'd3, 0, 3'd0);
        check_cycle(" R10 stack unchanged");

        // R2: unused kind codes are not branches
        set_group(1, 32'h0000_9000, 1, 3'd6, 1, 3'd7);
        check_cycle(" R2 unused codes");

        // Random groups
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            fv    = ($urandom_range(0, 15) != 0);
            redir = ($urandom_range(0, 31) == 0);
            rpc   = addr_t'($urandom) & ~addr_t'(3);
            pc    = addr_t'($urandom) & ~addr_t'(7);
            hit   = 2'($urandom);
            dir   = 2'($urandom);
            for (int s = 0; s < 2; s++) begin
                kind[s] = 3'($urandom_range(0, 4));
                btb[s]  = addr_t'($urandom) & ~addr_t'(3);
                ind[s]  = addr_t'($urandom) & ~addr_t'(3);
            end
            check_cycle(" random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule